// File: doc/BRIEF.md
# Receive Link Error Aggregation and Recovery Controller

This block gathers single-cycle error pulses from the sources around a serial receive link: the timing reference, header and multiblock alignment, CRC checking, the per-lane gearbox FIFOs, flow control, clock recovery, ECC and the system PLL. Every pulse is latched into a sticky status register. A per-bit enable mask forms the interrupt to the processor, and software clears status bits by writing 1 to them.

Each error class has its own recovery action, fixed in hardware. Some classes request a link reinitialization, which goes out as a single pulse followed by a holdoff window. Gearbox faults raise a reset request that stays asserted until software clears it. The remaining classes are only reported. A CRC error retries a limited number of times and then escalates to software. Corrected-ECC events are counted in a saturating counter.

Top module: `lnk_err_ctrl`

## Requirements
- R1: `err_i` bit map: 0 timing reference, 1 header-alignment loss, 2 multiblock-alignment loss, 3 CRC, 4 gearbox overflow, 5 gearbox underflow, 6 ready-deassert, 7 CDR unlock, 8 uncorrectable ECC, 9 system PLL lock loss. A pulse on bit n sets status bit n on the next edge, and that bit stays set. Bit 9 is latched only while `link_up_i` is high. Status bit 10 is the CRC escalation flag.
- R2: A write to address 0 clears every status bit whose data bit is 1. A set in the same cycle wins over the clear.
- R3: `irq_o` is high exactly when some status bit and its enable bit (address 1, bits 10:0, reset 0) are both 1.
- R4: A header or multiblock alignment loss always produces a one-cycle `reinit_o` pulse on the edge after the error. A timing-reference error does the same only while control bit 0 (address 2, reset 1) is set. Interrupt enables have no effect on this.
- R5: After a `reinit_o` pulse, reinit triggers on the following 256 edges are ignored. Their status bits are still latched.
- R6: A CRC error produces a reinit. After 3 reinits caused only by CRC, the next CRC error outside the holdoff sets status bit 10 and produces no reinit. While bit 10 is set, CRC errors cause no reinit. Any write of 1 to status bit 10 restarts the attempt count, and so does any reinit that has a non-CRC cause.
- R7: A gearbox overflow or underflow sets `rst_req_o`, which stays high until a write to address 2 with bit 1 set. A set in the same cycle wins. Control read bit 1 shows `rst_req_o`.
- R8: Ready-deassert, CDR-unlock, uncorrectable-ECC and PLL errors cause neither a reinit nor a reset request.
- R9: Each cycle with `ecc_corr_i` high increments a 16-bit counter (address 3) that saturates at 0xFFFF. Any write to address 3 clears it, and the clear wins over an increment in the same cycle.
- R10: `reg_rdata_o` shows the register at `reg_addr_i` combinationally: 0 status, 1 enable, 2 control, 3 ECC count. Unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| err_i | input | 10 | Error pulses, one per source |
| ecc_corr_i | input | 1 | Corrected-ECC event |
| link_up_i | input | 1 | Link is up; qualifies the PLL error |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data |
| irq_o | output | 1 | Interrupt |
| reinit_o | output | 1 | Link reinitialization pulse |
| rst_req_o | output | 1 | Full reset request |

## Verification
The bench sends triggers during the holdoff window. A design that miscounted the window would emit a second `reinit_o` too early or too late. It runs CRC errors through the whole retry sequence and past escalation. A design with an off-by-one attempt count would retry four times, or escalate after two. It also covers a set and a clear in the same cycle, the PLL error while the link is down, the timing-reference reinit with its control bit off, and the ECC counter held at saturation. A design that got any of these wrong would show a stale status bit, a spurious reinit, or a counter that wraps to zero.

// File: rtl/lec_pkg.sv
package lec_pkg;
  localparam int NUM_SRC  = 10;
  localparam int NUM_STAT = 11;
  localparam int DATA_W   = 16;

  localparam int B_TREF = 0;
  localparam int B_HDR  = 1;
  localparam int B_MB   = 2;
  localparam int B_CRC  = 3;
  localparam int B_GBO  = 4;
  localparam int B_GBU  = 5;
  localparam int B_RDY  = 6;
  localparam int B_CDR  = 7;
  localparam int B_ECCF = 8;
  localparam int B_PLL  = 9;
  localparam int B_ESC  = 10;

  typedef enum logic [1:0] {A_STAT = 2'd0, A_EN = 2'd1, A_CTRL = 2'd2, A_ECC = 2'd3} reg_addr_e;

  typedef enum logic [2:0] {
    ACT_REPORT, ACT_REINIT, ACT_REINIT_OPT, ACT_RETRY, ACT_RESET
  } act_e;

  function automatic act_e src_action(int idx);
    case (idx)
      B_TREF:       return ACT_REINIT_OPT;
      B_HDR, B_MB:  return ACT_REINIT;
      B_CRC:        return ACT_RETRY;
      B_GBO, B_GBU: return ACT_RESET;
      default:      return ACT_REPORT;
    endcase
  endfunction
endpackage

// File: rtl/lec_status.sv
module lec_status
  import lec_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_STAT-1:0] set_i,
  input  logic [NUM_STAT-1:0] clr_i,
  input  logic [NUM_STAT-1:0] en_i,
  output logic [NUM_STAT-1:0] status_o,
  output logic                irq_o
);
  logic [NUM_STAT-1:0] status_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clr_i) | set_i;
  end

  assign status_o = status_q;
  assign irq_o    = |(status_q & en_i);

  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_q & $past(status_q & ~clr_i)) == $past(status_q & ~clr_i))); // R1
  AST_SET_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_q & $past(set_i)) == $past(set_i))); // R2
endmodule

// File: rtl/lec_recovery.sv
module lec_recovery
  import lec_pkg::*;
#(
  parameter int HOLDOFF_CYC = 256,
  parameter int CRC_MAX     = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               tref_en_i,
  input  logic               esc_i,
  input  logic               esc_clr_i,
  input  logic               rst_clr_i,
  output logic               esc_set_o,
  output logic               reinit_o,
  output logic               rst_req_o
);
  localparam int HW = $clog2(HOLDOFF_CYC + 1);
  localparam int CW = $clog2(CRC_MAX + 1);

  logic [NUM_SRC-1:0] hard_v, rst_v, crc_v;
  logic [HW-1:0]      hold_q;
  logic [CW-1:0]      crc_cnt_q;
  logic               reinit_q, rst_req_q;
  logic               hard_trig, crc_trig, idle, crc_go, fire;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    localparam act_e ACT = src_action(i);
    assign hard_v[i] = src_i[i] & ((ACT == ACT_REINIT) | ((ACT == ACT_REINIT_OPT) & tref_en_i));
    assign rst_v[i]  = src_i[i] & (ACT == ACT_RESET);
    assign crc_v[i]  = src_i[i] & (ACT == ACT_RETRY);
  end

  assign hard_trig = |hard_v;
  assign crc_trig  = |crc_v;
  assign idle      = (hold_q == '0);
  assign crc_go    = crc_trig && !esc_i && (crc_cnt_q < CW'(CRC_MAX));
  assign fire      = idle && (hard_trig || crc_go);
  assign esc_set_o = idle && crc_trig && !hard_trig && !esc_i && (crc_cnt_q == CW'(CRC_MAX));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reinit_q  <= 1'b0;
      hold_q    <= '0;
      crc_cnt_q <= '0;
      rst_req_q <= 1'b0;
    end else begin
      reinit_q <= fire;
      if (fire)        hold_q <= HW'(HOLDOFF_CYC);
      else if (!idle)  hold_q <= hold_q - 1'b1;
      if (esc_clr_i)               crc_cnt_q <= '0;
      else if (fire && hard_trig)  crc_cnt_q <= '0;
      else if (fire)               crc_cnt_q <= crc_cnt_q + 1'b1;
      if (|rst_v)          rst_req_q <= 1'b1;
      else if (rst_clr_i)  rst_req_q <= 1'b0;
    end
  end

  assign reinit_o  = reinit_q;
  assign rst_req_o = rst_req_q;

  AST_REINIT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reinit_q |=> !reinit_q); // R4
  AST_HOLDOFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_q != '0) |=> !reinit_q); // R5
  AST_ESC_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (esc_i && crc_trig && !hard_trig) |=> !reinit_q); // R6
  AST_RST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_req_q && !rst_clr_i) |=> rst_req_q); // R7
endmodule

// File: rtl/lec_ecc_cnt.sv
module lec_ecc_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             sat;

  assign sat = &cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (clr_i)         cnt_q <= '0;
    else if (inc_i && !sat) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  AST_ECC_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sat && !clr_i) |=> (&cnt_q)); // R9
  AST_ECC_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0)); // R9
endmodule

// File: rtl/lnk_err_ctrl.sv
module lnk_err_ctrl
  import lec_pkg::*;
#(
  parameter int HOLDOFF_CYC = 256,
  parameter int CRC_MAX     = 3,
  parameter int ECC_W       = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] err_i,
  input  logic               ecc_corr_i,
  input  logic               link_up_i,
  input  logic               reg_we_i,
  input  logic [1:0]         reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  output logic               irq_o,
  output logic               reinit_o,
  output logic               rst_req_o
);
  logic [NUM_STAT-1:0] en_q, status, set_v, clr_v;
  logic [NUM_SRC-1:0]  src_q;
  logic [ECC_W-1:0]    ecc_cnt;
  logic                tref_en_q, esc_set;
  logic                wr_stat, wr_en, wr_ctrl, wr_ecc;

  assign wr_stat = reg_we_i && (reg_addr_e'(reg_addr_i) == A_STAT);
  assign wr_en   = reg_we_i && (reg_addr_e'(reg_addr_i) == A_EN);
  assign wr_ctrl = reg_we_i && (reg_addr_e'(reg_addr_i) == A_CTRL);
  assign wr_ecc  = reg_we_i && (reg_addr_e'(reg_addr_i) == A_ECC);

  // PLL loss only counts while the link is up
  always_comb begin
    src_q        = err_i;
    src_q[B_PLL] = err_i[B_PLL] & link_up_i;
  end

  assign set_v = {esc_set, src_q};
  assign clr_v = wr_stat ? reg_wdata_i[NUM_STAT-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q      <= '0;
      tref_en_q <= 1'b1;
    end else begin
      if (wr_en)   en_q      <= reg_wdata_i[NUM_STAT-1:0];
      if (wr_ctrl) tref_en_q <= reg_wdata_i[0];
    end
  end

  lec_status u_status (
    .clk_i, .rst_ni,
    .set_i(set_v), .clr_i(clr_v), .en_i(en_q),
    .status_o(status), .irq_o(irq_o)
  );

  lec_recovery #(.HOLDOFF_CYC(HOLDOFF_CYC), .CRC_MAX(CRC_MAX)) u_recovery (
    .clk_i, .rst_ni,
    .src_i(src_q), .tref_en_i(tref_en_q),
    .esc_i(status[B_ESC]), .esc_clr_i(clr_v[B_ESC]),
    .rst_clr_i(wr_ctrl && reg_wdata_i[1]),
    .esc_set_o(esc_set), .reinit_o(reinit_o), .rst_req_o(rst_req_o)
  );

  lec_ecc_cnt #(.CNT_W(ECC_W)) u_ecc (
    .clk_i, .rst_ni,
    .inc_i(ecc_corr_i), .clr_i(wr_ecc), .cnt_o(ecc_cnt)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_e'(reg_addr_i))
      A_STAT:  reg_rdata_o[NUM_STAT-1:0] = status;
      A_EN:    reg_rdata_o[NUM_STAT-1:0] = en_q;
      A_CTRL:  reg_rdata_o[1:0]          = {rst_req_o, tref_en_q};
      default: reg_rdata_o               = DATA_W'(ecc_cnt);
    endcase
  end

  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q == '0) |-> !irq_o); // R3
  AST_TREF_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tref_en_q && (err_i & ~(NUM_SRC'(1) << B_TREF)) == '0) |=> !reinit_o); // R4
  AST_REPORT_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rst_req_o && (err_i & NUM_SRC'(10'b0000110000)) == '0) |=> !rst_req_o || $past(wr_ctrl)); // R8
endmodule

// File: tb/lnk_err_ctrl_bench.sv
module lnk_err_ctrl_bench;
  logic        clk = 0, rst_ni = 0;
  logic [9:0]  err = '0;
  logic        ecc_corr = 0, link_up = 0, we = 0;
  logic [1:0]  addr = 0;
  logic [15:0] wdata = 0;
  logic [15:0] rdata;
  logic        irq, reinit, rst_req;

  int tests = 0, fails = 0, reinit_seen = 0;
  bit done = 0;

  // reference model state
  int m_status = 0, m_en = 0, m_tref_en = 1, m_rst = 0, m_ecc = 0;
  int m_hold = 0, m_crc = 0, m_reinit = 0;

  always #2 clk = ~clk;

  lnk_err_ctrl u_lnk_err_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .err_i(err), .ecc_corr_i(ecc_corr),
    .link_up_i(link_up), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq), .reinit_o(reinit), .rst_req_o(rst_req)
  );

  task automatic check(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_step();
    int src, hard, crc, idle, fire, escset, esc, clr, n_status;
    src = int'(err);
    if (!link_up) src = src & ~(1 << 9);
    esc  = (m_status >> 10) & 1;
    hard = (src >> 1 & 1) | (src >> 2 & 1) | ((src & 1) & m_tref_en);
    crc  = (src >> 3) & 1;
    idle = (m_hold == 0);
    fire = idle && (hard || (crc && !esc && m_crc < 3));
    escset = idle && crc && !hard && !esc && m_crc == 3;
    clr = (we && addr == 0) ? int'(wdata) & 'h7FF : 0;
    n_status = (m_status & ~clr) | src | (escset << 10);
    if (clr & (1 << 10))  m_crc = 0;
    else if (fire && hard) m_crc = 0;
    else if (fire)         m_crc++;
    if (fire) m_hold = 256; else if (!idle) m_hold--;
    m_reinit = fire;
    if (src & 'h30) m_rst = 1;
    else if (we && addr == 2 && wdata[1]) m_rst = 0;
    if (we && addr == 1) m_en = int'(wdata) & 'h7FF;
    if (we && addr == 2) m_tref_en = wdata[0];
    if (we && addr == 3) m_ecc = 0;
    else if (ecc_corr && m_ecc < 'hFFFF) m_ecc++;
    m_status = n_status;
  endtask

  function automatic int m_rdata();
    case (addr)
      2'd0: return m_status;
      2'd1: return m_en;
      2'd2: return (m_rst << 1) | m_tref_en;
      default: return m_ecc;
    endcase
  endfunction

  task automatic compare();
    string t;
    check("R3 irq", int'(irq), ((m_status & m_en) != 0) ? 1 : 0);
    check("R4 R5 R6 reinit", int'(reinit), m_reinit);
    check("R7 R8 rst_req", int'(rst_req), m_rst);
    case (addr)
      2'd0: t = "R1 R2 status read";
      2'd1: t = "R10 enable read";
      2'd2: t = "R7 R10 control read";
      default: t = "R9 ecc read";
    endcase
    check(t, int'(rdata), m_rdata());
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    if (reinit) reinit_seen++;
    compare();
  endtask

  task automatic idle_n(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic pulse(int idx);
    err = 10'(1 << idx);
    cyc();
    err = '0;
  endtask

  task automatic wr(int a, int d);
    we = 1; addr = 2'(a); wdata = 16'(d);
    cyc();
    we = 0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    @(negedge clk);
    // reset state, R10
    check("R10 reset status", int'(rdata), 0);
    check("R4 reset reinit", int'(reinit), 0);
    check("R7 reset rst_req", int'(rst_req), 0);
    @(negedge clk); rst_ni = 1;
    for (int a = 0; a < 4; a++) begin addr = 2'(a); cyc(); end
    addr = 0;
    // R3 enables
    wr(1, 'h7FF);
    addr = 0;
    // R4 alignment losses
    pulse(1); idle_n(300);
    pulse(2); idle_n(10);
    // R5 trigger inside holdoff ignored
    pulse(1); idle_n(240); pulse(2); idle_n(10);
    // R2 clear all, with set in same cycle
    err = 10'b10; we = 1; addr = 0; wdata = 'h7FF; cyc(); we = 0; err = 0;
    wr(0, 'h7FF); addr = 0; idle_n(2);
    // R4 timing reference with control on and off
    pulse(0); idle_n(260);
    wr(2, 0); addr = 2; cyc();
    pulse(0); idle_n(3);
    wr(2, 1); addr = 0;
    // R6 CRC retry and escalation
    reinit_seen = 0;
    for (int k = 0; k < 4; k++) begin pulse(3); idle_n(260); end
    check("R6 crc attempts", reinit_seen, 3);
    check("R6 escalation bit", (int'(rdata) >> 10) & 1, 1);
    pulse(3); idle_n(5);
    check("R6 no reinit while escalated", reinit_seen, 3);
    wr(0, 'h408); addr = 0;
    pulse(3); idle_n(5);
    check("R6 retry after clear", reinit_seen, 4);
    idle_n(260);
    // R7 reset request
    pulse(4); idle_n(5);
    addr = 2; cyc();
    wr(2, 'h3); addr = 2; cyc();
    pulse(5); err = 10'b10_0000; we = 1; wdata = 'h3; cyc(); we = 0; err = 0;
    check("R7 set wins over clear", int'(rst_req), 1);
    wr(2, 'h3); addr = 0;
    // R8 report only, R1 PLL gating
    wr(0, 'h7FF); addr = 0;
    link_up = 0; pulse(9); idle_n(2);
    check("R1 pll ignored link down", (int'(rdata) >> 9) & 1, 0);
    link_up = 1;
    for (int b = 6; b < 10; b++) begin pulse(b); idle_n(3); end
    check("R8 report only status", int'(rdata) & 'h3C0, 'h3C0);
    // R3 masked interrupt
    wr(1, 'h001); addr = 0; idle_n(2);
    wr(1, 'h200); addr = 0; idle_n(2);
    // R9 ECC counting, saturation, clear
    addr = 3;
    ecc_corr = 1; idle_n(70);
    wr(3, 0); addr = 3;
    idle_n(65540);
    check("R9 saturated", int'(rdata), 'hFFFF);
    we = 1; wdata = 0; cyc(); we = 0;
    check("R9 clear wins", int'(rdata), 0);
    ecc_corr = 0; idle_n(3);
    summary();
  end
endmodule